// File: doc/BRIEF.md
# Write-Masked Protected RAM

This block is a single-port synchronous RAM for an 8-bit bus. Its storage is cut into equal regions. Each region has one write-enable bit in a mask register. A CPU write to a region reaches the array only when that region's mask bit is set. Blocked writes leave the array untouched and raise a one-cycle violation flag. Reads are never restricted.

The mask register has its own bus address, so a read of that address returns the current mask. The register can only be changed while the processor's privilege bit, which comes in on an input, is high. The mask comes out of reset with every bit set. Initialization code can therefore fill memory and then program the mask while still privileged. Only after that does it drop privilege and let protection take hold. A separate write-qualification input must also be high before any bus write has an effect.

Top module: `prot_ram`

## Requirements
- R1: After reset, `rd_data_o` is 0x00, `viol_o` is 0, and the mask reads 0xFF (all 8 regions writable).
- R2: A read with `rd_en_i` high presents the addressed byte on `rd_data_o` one clock later.
- R3: With `addr_i[12]` = 0, the region is `addr_i[11:9]` (8 regions of 512 bytes). A qualified write to a region whose mask bit (bit n for region n) is 1 updates that byte.
- R4: A qualified write to a region whose mask bit is 0 is discarded, and the byte keeps its old value.
- R5: Any address with `addr_i[12]` = 1 selects the mask register. A read there returns the mask in bits [7:0], with the same one-cycle latency, whatever the level of `priv_i`.
- R6: A qualified write to the mask register loads `wr_data_i` only when `priv_i` is 1. With `priv_i` at 0 the mask is unchanged.
- R7: A write with `wr_qual_i` at 0 changes neither memory nor mask and raises no violation.
- R8: `viol_o` is high for exactly the one cycle after a qualified write that was blocked, whether by a clear mask bit or by a mask write without privilege. It is low otherwise.
- R9: While `rd_en_i` is 0, `rd_data_o` holds its last value, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Byte address; bit 12 selects the mask register |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Write data |
| wr_qual_i | input | 1 | Write qualification; a write counts only when high |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| priv_i | input | 1 | Processor privilege bit; unlocks mask writes |
| viol_o | output | 1 | One-cycle pulse on a blocked write |

## Verification
A corrupted mask shows up in two ways. The first is a read of the mask address one cycle later. The second is a wrong `viol_o` in the cycle after the next write to the affected region, or a changed byte on the read that follows. A region decode that uses the wrong address bits lets a write at a region edge (0x1FF, 0xFFF) land or be blocked wrongly, and a read-back of that byte shows it within two cycles. A broken privilege or qualification gate appears as a mask value that changes when it should not, on the very next mask read.

// File: rtl/prot_ram_pkg.sv
package prot_ram_pkg;
  localparam int unsigned ADDR_W_DEF   = 12;  // array address bits
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned REGION_W_DEF = 3;   // log2 of region count
endpackage

// File: rtl/prot_ram_decode.sv
module prot_ram_decode #(
  parameter int unsigned REGION_W = 3,
  localparam int unsigned NREG    = 1 << REGION_W
) (
  input  logic                wr_en_i,
  input  logic                wr_qual_i,
  input  logic                priv_i,
  input  logic                mask_sel_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic [NREG-1:0]     mask_i,
  output logic                ram_we_o,
  output logic                mask_we_o,
  output logic                blocked_o
);
  logic wr_eff;

  always_comb begin
    wr_eff    = wr_en_i & wr_qual_i;
    ram_we_o  = wr_eff & ~mask_sel_i & mask_i[region_i];
    mask_we_o = wr_eff & mask_sel_i & priv_i;
    blocked_o = wr_eff & ~(ram_we_o | mask_we_o);
  end
endmodule

// File: rtl/prot_ram_mask.sv
module prot_ram_mask #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NREG-1:0]   mask_o,
  output logic [DATA_W-1:0] mask_rd_o
);
  logic [NREG-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i[NREG-1:0];
  end

  assign mask_o = mask_q;

  // zero-extend the mask onto the data bus
  generate
    if (NREG < DATA_W) begin : g_pad
      assign mask_rd_o = {{(DATA_W-NREG){1'b0}}, mask_q};
    end else begin : g_full
      assign mask_rd_o = mask_q;
    end
  endgenerate

  assert_mask_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_q) |-> $past(we_i));
  assert_mask_priv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> priv_i);
endmodule

// File: rtl/prot_ram_array.sv
module prot_ram_array #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // read-first: same-cycle write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= mem_q[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/prot_ram.sv
module prot_ram
  import prot_ram_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned REGION_W = REGION_W_DEF,
  localparam int unsigned NREG    = 1 << REGION_W,
  localparam int unsigned BUS_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_qual_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              priv_i,
  output logic              viol_o
);
  logic                mask_sel;
  logic [REGION_W-1:0] region;
  logic [NREG-1:0]     mask;
  logic [DATA_W-1:0]   mask_rd;
  logic [DATA_W-1:0]   ram_rd;
  logic                ram_we, mask_we, blocked;
  logic                sel_q, viol_q;
  logic [DATA_W-1:0]   mask_rd_q;

  assign mask_sel = addr_i[ADDR_W];
  assign region   = addr_i[ADDR_W-1 -: REGION_W];

  prot_ram_decode #(.REGION_W(REGION_W)) i_decode (
    .wr_en_i    (wr_en_i),
    .wr_qual_i  (wr_qual_i),
    .priv_i     (priv_i),
    .mask_sel_i (mask_sel),
    .region_i   (region),
    .mask_i     (mask),
    .ram_we_o   (ram_we),
    .mask_we_o  (mask_we),
    .blocked_o  (blocked)
  );

  prot_ram_mask #(.DATA_W(DATA_W), .NREG(NREG)) i_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mask_we),
    .priv_i    (priv_i),
    .wdata_i   (wr_data_i),
    .mask_o    (mask),
    .mask_rd_o (mask_rd)
  );

  prot_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .re_i    (rd_en_i & ~mask_sel),
    .addr_i  (addr_i[ADDR_W-1:0]),
    .wdata_i (wr_data_i),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      mask_rd_q <= '0;
      viol_q    <= 1'b0;
    end else begin
      viol_q <= blocked;
      if (rd_en_i) begin
        sel_q <= mask_sel;
        if (mask_sel) mask_rd_q <= mask_rd;
      end
    end
  end

  assign rd_data_o = sel_q ? mask_rd_q : ram_rd;
  assign viol_o    = viol_q;

  assert_ram_we_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> mask[region]);
  assert_one_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we && mask_we));
  assert_no_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_qual_i |-> !(ram_we || mask_we || blocked));
  assert_viol_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(wr_en_i && wr_qual_i));
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/test_prot_ram.sv
module test_prot_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0, wr_qual = 1'b0, rd_en = 1'b0, priv = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        viol;
  int          checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  prot_ram i_prot_ram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_qual_i(wr_qual), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .priv_i(priv), .viol_o(viol)
  );

  typedef struct packed {
    logic        rd;
    logic [12:0] a;
    logic [7:0]  d;
    logic        q;
    logic        p;
    logic [7:0]  exp;
    logic        ev;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'h1000, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd5}, // R5 mask after reset
    '{1'b0, 13'h0000, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3}, // R3
    '{1'b1, 13'h0000, 8'h00, 1'b0, 1'b0, 8'hA5, 1'b0, 4'd2}, // R2
    '{1'b0, 13'h0E00, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3}, // R3 region 7
    '{1'b1, 13'h0E00, 8'h00, 1'b0, 1'b0, 8'h3C, 1'b0, 4'd3}, // R3
    '{1'b0, 13'h1000, 8'h7E, 1'b1, 1'b0, 8'h00, 1'b1, 4'd6}, // R6 unprivileged
    '{1'b1, 13'h1000, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd6}, // R6 unchanged
    '{1'b0, 13'h1000, 8'h7E, 1'b1, 1'b1, 8'h00, 1'b0, 4'd6}, // R6 privileged
    '{1'b1, 13'h1000, 8'h00, 1'b0, 1'b0, 8'h7E, 1'b0, 4'd5}, // R5 priv low
    '{1'b1, 13'h1FFF, 8'h00, 1'b0, 1'b1, 8'h7E, 1'b0, 4'd5}, // R5 alias, priv high
    '{1'b0, 13'h0000, 8'h11, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4}, // R4
    '{1'b1, 13'h0000, 8'h00, 1'b0, 1'b0, 8'hA5, 1'b0, 4'd4}, // R4
    '{1'b0, 13'h0FFF, 8'h22, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 top edge
    '{1'b1, 13'h0E00, 8'h00, 1'b0, 1'b0, 8'h3C, 1'b0, 4'd4}, // R4
    '{1'b0, 13'h0200, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3}, // R3 region 1
    '{1'b1, 13'h0200, 8'h00, 1'b0, 1'b0, 8'h5A, 1'b0, 4'd3}, // R3
    '{1'b0, 13'h01FF, 8'h99, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 region 0 edge
    '{1'b0, 13'h0200, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 4'd7}, // R7 unqualified
    '{1'b1, 13'h0200, 8'h00, 1'b0, 1'b0, 8'h5A, 1'b0, 4'd7}, // R7
    '{1'b0, 13'h1000, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd7}, // R7 mask unqualified
    '{1'b1, 13'h1000, 8'h00, 1'b0, 1'b0, 8'h7E, 1'b0, 4'd7}, // R7
    '{1'b0, 13'h1000, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b0, 4'd6}, // R6 reopen
    '{1'b0, 13'h0000, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3}  // R3 now allowed
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic op(input logic r, input logic [12:0] a, input logic [7:0] d,
                    input logic q, input logic p);
    rd_en = r; wr_en = ~r; addr = a; wr_data = d; wr_qual = q; priv = p;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wr_qual = 1'b0;
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0; wr_qual = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 viol", {7'd0, viol}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].rd, VEC[i].a, VEC[i].d, VEC[i].q, VEC[i].p);
      chk($sformatf("R%0d vec %0d viol", VEC[i].req, i), {7'd0, viol}, {7'd0, VEC[i].ev});
      if (VEC[i].rd)
        chk($sformatf("R%0d vec %0d data", VEC[i].req, i), rd_data, VEC[i].exp);
    end

    // R3: byte written by the last vector
    op(1'b1, 13'h0000, 8'h00, 1'b0, 1'b0);
    chk("R3 reopened write", rd_data, 8'h11);

    // R8: blocked write pulses for one cycle only
    op(1'b0, 13'h1000, 8'hFE, 1'b1, 1'b1);   // clear region 0
    chk("R8 no viol on mask write", {7'd0, viol}, 8'h00);
    op(1'b0, 13'h0010, 8'h77, 1'b1, 1'b0);
    chk("R8 viol high", {7'd0, viol}, 8'h01);
    idle();
    chk("R8 viol low after one cycle", {7'd0, viol}, 8'h00);

    // R9: read data held while rd_en low, across an allowed write
    op(1'b1, 13'h0200, 8'h00, 1'b0, 1'b0);
    chk("R9 read", rd_data, 8'h5A);
    op(1'b0, 13'h0200, 8'hC3, 1'b1, 1'b0);
    chk("R9 held across write", rd_data, 8'h5A);
    idle();
    chk("R9 held idle", rd_data, 8'h5A);
    op(1'b1, 13'h0200, 8'h00, 1'b0, 1'b0);
    chk("R9 new value visible", rd_data, 8'hC3);

    // R1: reset mid-run restores mask to all ones
    op(1'b0, 13'h1000, 8'h00, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b1, 13'h1000, 8'h00, 1'b0, 1'b0);
    chk("R1 mask after reset", rd_data, 8'hFF);

    finish_run();
  end
endmodule